// File: doc/BRIEF.md
# Memory Bus Self-Test Engine

This block is a built-in self-test master for a byte-wide memory that sits behind a simple synchronous port. The port has an address, write data, a write strobe, a read strobe, and read data that returns a fixed number of cycles after the read. After a start pulse the engine runs four checks in a fixed order:

1. A walking-one check of the data lines.
2. A check of every address line.
3. An overlap check that finds address lines that alias onto each other.
4. A sweep over every cell.

Each written value is read back and compared before the engine issues the next access. The first mismatch stops the run and freezes a report: the code of the failing check, the address and the byte that came back. A clean run ends with pass high.

The controller is a single state machine with six states:

- `ST_IDLE`: wait for start.
- `ST_WRITE`: one write cycle.
- `ST_READ`: one read cycle at the same address.
- `ST_WAIT`: the read-latency window, ending in the comparison.
- `ST_MARK`: the single write of 0x55 to address 0 that opens the overlap check.
- `ST_DONE`: the result is held.

The transitions are:

- start: `ST_IDLE` or `ST_DONE` to `ST_WRITE`.
- `ST_WRITE` to `ST_READ`.
- `ST_READ` to `ST_WAIT`.
- compare-ok: `ST_WAIT` to `ST_WRITE`, `ST_READ` (overlap check only), `ST_MARK` (after the last address-line access) or `ST_DONE` (after the last cell).
- mismatch: `ST_WAIT` to `ST_DONE`.
- `ST_MARK` to `ST_READ`.

Memory size is 2^ADDR_W bytes. The default ADDR_W is 24, which gives 16 MiB. The read latency is the parameter RD_LAT.

Top module: `membus_selftest`

## Requirements
- R1: While reset is held and just after it, done, pass, busy, mem_we and mem_re are all 0.
- R2: Check code 1 (data lines): bytes 0x01, 0x02, ... 0x80 are each written to address 0 and read back. A mismatch reports code 1, address 0 and the byte read.
- R3: Check code 2 (address lines): 0xAA is written and read back at every address 2^k for k = 0 .. ADDR_W-1. A mismatch reports code 2 and that address.
- R4: Check code 3 (overlap): 0x55 is written once to address 0. Then every address 2^k is read again, expecting 0xAA. A mismatch reports code 3, that address and the byte read.
- R5: Check code 4 (full array): 0xAA is written and read back at every address from 0 up to 2^ADDR_W-1 in rising order. Afterwards every cell holds 0xAA. A mismatch reports code 4 and the address.
- R6: On the first mismatch the engine stops, asserts done with pass low and a code in 1..4, and issues no further memory access.
- R7: A run with no mismatch ends with done high, pass high and code 0.
- R8: Read data is compared RD_LAT cycles after the read cycle, and no access is issued before that comparison. A clean run takes 8(2+L) + W(2+L) + 1 + W(1+L) + 2^W(2+L) cycles from the start edge to done, where L = RD_LAT and W = ADDR_W. For W=8 and L=2 that is 1113 edges.
- R9: A start pulse while busy is ignored. Once done is high, done and the report stay unchanged until the next start, which begins a new run.
- R10: mem_we and mem_re are never high together. busy is high from the cycle after an accepted start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A run has finished; report valid |
| pass | output | 1 | Run finished with no mismatch |
| fail_phase | output | 3 | Code of the failing check (0 on pass) |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_data | output | 8 | Byte read at the first mismatch |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid RD_LAT cycles after a read |

## Verification
A wrong state or phase register shows up at the memory port within one access. Either a write is not followed by a read of the same address, or the overlap write lands somewhere other than address 0, or the run length from start to done drifts from the exact count. A wrong address step or a wrong pattern shows up as a false fail, or as a missed fail with the wrong code or address, in the report frozen at done.

Faults are injected into a bench memory model: stuck data bits, stuck cells at chosen addresses, and an ignored address bit. Each fault targets one check and has a known first failing address, so the report can be compared exactly.

// File: rtl/membus_pkg.sv
package membus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_WAIT,
        ST_MARK,
        ST_DONE
    } st_e;

    typedef enum logic [2:0] {
        PH_NONE  = 3'd0,
        PH_DATA  = 3'd1,
        PH_ADDR  = 3'd2,
        PH_ALIAS = 3'd3,
        PH_FULL  = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        AOP_HOLD,
        AOP_ZERO,
        AOP_ONE,
        AOP_SHL,
        AOP_INC
    } aop_e;

    localparam logic [7:0] PAT_MAIN  = 8'hAA;
    localparam logic [7:0] PAT_ANTI  = 8'h55;
    localparam logic [7:0] PAT_WALK0 = 8'h01;

endpackage

// File: rtl/membus_addr_gen.sv
module membus_addr_gen
    import membus_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  aop_e              op,
    output logic [ADDR_W-1:0] addr,
    output logic              at_top_pow2,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else begin
            unique case (op)
                AOP_ZERO: addr <= '0;
                AOP_ONE:  addr <= ADDR_ONE;
                AOP_SHL:  addr <= {addr[ADDR_W-2:0], 1'b0};
                AOP_INC:  addr <= addr + ADDR_ONE;
                default:  addr <= addr;
            endcase
        end
    end

    // the highest power-of-two address has only its top bit set
    assign at_top_pow2 = addr[ADDR_W-1];
    assign at_last     = &addr;

endmodule

// File: rtl/membus_lat_timer.sv
module membus_lat_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/membus_result.sv
module membus_result #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_pass,
    input  logic              set_fail,
    input  logic [2:0]        in_phase,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [7:0]        in_data,
    output logic              done,
    output logic              pass,
    output logic [2:0]        out_phase,
    output logic [ADDR_W-1:0] out_addr,
    output logic [7:0]        out_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            pass      <= 1'b0;
            out_phase <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (clr) begin
            done      <= 1'b0;
            pass      <= 1'b0;
            out_phase <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (set_fail) begin
            done      <= 1'b1;
            pass      <= 1'b0;
            out_phase <= in_phase;
            out_addr  <= in_addr;
            out_data  <= in_data;
        end else if (set_pass) begin
            done      <= 1'b1;
            pass      <= 1'b1;
            out_phase <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end
    end

endmodule

// File: rtl/membus_selftest.sv
module membus_selftest
    import membus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [2:0]        fail_phase,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [7:0]        fail_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);

    st_e        state_q, state_d;
    phase_e     phase_q, phase_d;
    logic [7:0] pat_q, pat_d;
    aop_e       aop;

    logic [ADDR_W-1:0] addr;
    logic              at_top_pow2;
    logic              at_last;
    logic              lat_expired;
    logic              cmp_now;
    logic              mismatch;
    logic              res_clr;
    logic              res_pass;
    logic              res_fail;

    membus_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (aop),
        .addr        (addr),
        .at_top_pow2 (at_top_pow2),
        .at_last     (at_last)
    );

    membus_lat_timer #(.LAT(RD_LAT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state_q == ST_READ),
        .expired (lat_expired)
    );

    membus_result #(.ADDR_W(ADDR_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (res_clr),
        .set_pass  (res_pass),
        .set_fail  (res_fail),
        .in_phase  (phase_q),
        .in_addr   (addr),
        .in_data   (mem_rdata),
        .done      (done),
        .pass      (pass),
        .out_phase (fail_phase),
        .out_addr  (fail_addr),
        .out_data  (fail_data)
    );

    assign cmp_now  = (state_q == ST_WAIT) && lat_expired;
    assign mismatch = (mem_rdata != pat_q);

    // state, phase and pattern registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_NONE;
            pat_q   <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            pat_q   <= pat_d;
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        phase_d  = phase_q;
        pat_d    = pat_q;
        aop      = AOP_HOLD;
        res_clr  = 1'b0;
        res_pass = 1'b0;
        res_fail = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    res_clr = 1'b1;
                    phase_d = PH_DATA;
                    pat_d   = PAT_WALK0;
                    aop     = AOP_ZERO;
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: state_d = ST_READ;
            ST_READ:  state_d = ST_WAIT;
            ST_MARK: begin
                phase_d = PH_ALIAS;
                aop     = AOP_ONE;
                state_d = ST_READ;
            end
            ST_WAIT: begin
                if (cmp_now) begin
                    if (mismatch) begin
                        res_fail = 1'b1;
                        state_d  = ST_DONE;
                    end else begin
                        unique case (phase_q)
                            PH_DATA: begin
                                if (pat_q[7]) begin
                                    phase_d = PH_ADDR;
                                    pat_d   = PAT_MAIN;
                                    aop     = AOP_ONE;
                                end else begin
                                    pat_d   = {pat_q[6:0], 1'b0};
                                end
                                state_d = ST_WRITE;
                            end
                            PH_ADDR: begin
                                if (at_top_pow2) begin
                                    state_d = ST_MARK;
                                end else begin
                                    aop     = AOP_SHL;
                                    state_d = ST_WRITE;
                                end
                            end
                            PH_ALIAS: begin
                                if (at_top_pow2) begin
                                    phase_d = PH_FULL;
                                    aop     = AOP_ZERO;
                                    state_d = ST_WRITE;
                                end else begin
                                    aop     = AOP_SHL;
                                    state_d = ST_READ;
                                end
                            end
                            PH_FULL: begin
                                if (at_last) begin
                                    res_pass = 1'b1;
                                    state_d  = ST_DONE;
                                end else begin
                                    aop     = AOP_INC;
                                    state_d = ST_WRITE;
                                end
                            end
                            default: state_d = ST_DONE;
                        endcase
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = addr;
        mem_wdata = pat_q;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_DONE: busy = 1'b0;
            ST_WRITE:         mem_we = 1'b1;
            ST_READ:          mem_re = 1'b1;
            ST_MARK: begin
                mem_we    = 1'b1;
                mem_addr  = '0;
                mem_wdata = PAT_ANTI;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/membus_selftest_chk.sv
module membus_selftest_chk #(
    parameter int ADDR_W = 24,
    parameter int RD_LAT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [2:0]        fail_phase,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [7:0]        fail_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_we,
    input logic              mem_re
);

    localparam int GW = $clog2(RD_LAT + 2) + 1;
    localparam logic [GW-1:0] GAP_MAX = GW'(RD_LAT + 1);

    logic [GW-1:0] gap_q;
    logic          seen_rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= '0;
            seen_rd_q <= 1'b0;
        end else if (mem_re) begin
            gap_q     <= '0;
            seen_rd_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R10

    AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && seen_rd_q) |-> (gap_q >= GW'(RD_LAT))); // R8

    AST_WRITE_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wdata != 8'h55) |=> (mem_re && mem_addr == $past(mem_addr))); // R2

    AST_ANTI_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wdata == 8'h55) |-> (mem_addr == '0)); // R4

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re && !busy)); // R6

    AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (fail_phase >= 3'd1 && fail_phase <= 3'd4)); // R6

    AST_PASS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (fail_phase == 3'd0)); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail_phase)
                              && $stable(fail_addr) && $stable(fail_data))); // R9

endmodule

bind membus_selftest membus_selftest_chk #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail_phase (fail_phase),
    .fail_addr  (fail_addr),
    .fail_data  (fail_data),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re)
);

// File: tb/membus_selftest_tb.sv
module membus_selftest_tb;

    localparam int AW   = 8;
    localparam int LAT  = 2;
    localparam int SIZE = 1 << AW;
    localparam int RUN_CYC = 8*(2+LAT) + AW*(2+LAT) + 1 + AW*(1+LAT) + SIZE*(2+LAT) + 1;

    typedef struct {
        string    name;
        bit       pass;
        bit [2:0] phase;
        bit [7:0] addr;
        bit [7:0] data;
        int       lat;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, pass;
    logic [2:0]    fail_phase;
    logic [AW-1:0] fail_addr;
    logic [7:0]    fail_data;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we, mem_re;
    logic [7:0]    mem_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    int results = 0;
    exp_t sb_q[$];

    // memory model with fault injection
    logic [7:0] mem [0:SIZE-1];
    logic [7:0] rd_pipe [0:LAT-1];
    logic [7:0] stuck0 = 8'h00;
    logic [7:0] stuck1 = 8'h00;
    logic [7:0] alias_mask = 8'h00;
    logic       bad_en = 1'b0;
    logic [7:0] bad_addr = 8'h00;
    logic [7:0] bad_val = 8'h00;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr & ~alias_mask] <= mem_wdata;
        if (mem_re) begin
            if (bad_en && (mem_addr & ~alias_mask) == bad_addr)
                rd_pipe[0] <= bad_val;
            else
                rd_pipe[0] <= (mem[mem_addr & ~alias_mask] & ~stuck0) | stuck1;
        end else begin
            rd_pipe[0] <= 8'h00;
        end
        for (int i = 1; i < LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
    end
    assign mem_rdata = rd_pipe[LAT-1];

    membus_selftest #(.ADDR_W(AW), .RD_LAT(LAT)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .pass       (pass),
        .fail_phase (fail_phase),
        .fail_addr  (fail_addr),
        .fail_data  (fail_data),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_rdata  (mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the expected report when done rises
    initial begin
        logic prev_done;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && done && !prev_done && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.name, " pass"}, 32'(pass), 32'(e.pass));
                chk({e.name, " code"}, 32'(fail_phase), 32'(e.phase));
                if (!e.pass) begin
                    chk({e.name, " addr"}, 32'(fail_addr), 32'(e.addr));
                    chk({e.name, " data"}, 32'(fail_data), 32'(e.data));
                end
                if (e.lat >= 0) chk({e.name, " R8 run length"}, 32'(cyc - start_cyc), 32'(e.lat));
                results++;
            end
            prev_done = done;
        end
    end

    // driver: pushes the expected report, starts a run, waits for it
    task automatic run_case(input string name, input bit p, input bit [2:0] ph,
                            input bit [7:0] a, input bit [7:0] d, input int lat,
                            input bit poke);
        exp_t e;
        int want;
        e.name = name; e.pass = p; e.phase = ph; e.addr = a; e.data = d; e.lat = lat;
        sb_q.push_back(e);
        want = results + 1;
        @(negedge clk);
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        chk({name, " R10 busy after start"}, 32'(busy), 32'd1);
        chk({name, " R10 done cleared"}, 32'(done), 32'd0);
        if (poke) begin
            repeat (100) @(negedge clk);
            start = 1'b1;              // R9: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (results < want) @(negedge clk);
        // R6 / R9: quiet bus and frozen report after done
        begin
            logic [2:0] ph0;
            logic [7:0] a0;
            bit quiet;
            bit held;
            ph0 = fail_phase; a0 = fail_addr;
            quiet = 1'b1; held = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (mem_we || mem_re || busy) quiet = 1'b0;
                if (!done || fail_phase != ph0 || fail_addr != a0) held = 1'b0;
            end
            chk({name, " R6 no access after done"}, 32'(quiet), 32'd1);
            chk({name, " R9 report held"}, 32'(held), 32'd1);
        end
        stuck0 = 8'h00; stuck1 = 8'h00; alias_mask = 8'h00; bad_en = 1'b0;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < SIZE; i++) mem[i] = 8'h00;
        for (int i = 0; i < LAT; i++) rd_pipe[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 32'(done), 32'd0);
        chk("R1 busy in reset", 32'(busy), 32'd0);
        chk("R1 strobes in reset", 32'({mem_we, mem_re}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pass after reset", 32'(pass), 32'd0);
        chk("R1 busy after reset", 32'(busy), 32'd0);

        // R7 / R8: clean run, exact run length
        run_case("R7 clean", 1'b1, 3'd0, 8'h00, 8'h00, RUN_CYC, 1'b0);
        chk("R5 cell 0x00 holds AA", 32'(mem[0]), 32'hAA);
        chk("R5 cell 0x37 holds AA", 32'(mem[8'h37]), 32'hAA);
        chk("R5 last cell holds AA", 32'(mem[SIZE-1]), 32'hAA);

        // R9: start while busy ignored, restart from done
        run_case("R9 poke", 1'b1, 3'd0, 8'h00, 8'h00, RUN_CYC, 1'b1);

        // R2: data bit 3 stuck low, fails at 0x08
        stuck0 = 8'h08;
        run_case("R2 stuck0", 1'b0, 3'd1, 8'h00, 8'h00, -1, 1'b0);

        // R2: data bit 1 stuck high, fails on first byte
        stuck1 = 8'h02;
        run_case("R2 stuck1", 1'b0, 3'd1, 8'h00, 8'h03, -1, 1'b0);

        // R3: dead cell at address-line 0x10
        bad_en = 1'b1; bad_addr = 8'h10; bad_val = 8'h00;
        run_case("R3 addr line", 1'b0, 3'd2, 8'h10, 8'h00, -1, 1'b0);

        // R4: address bit 5 ignored, 0x20 aliases onto 0
        alias_mask = 8'h20;
        run_case("R4 overlap", 1'b0, 3'd3, 8'h20, 8'h55, -1, 1'b0);

        // R5: dead cell inside the array
        bad_en = 1'b1; bad_addr = 8'h37; bad_val = 8'h00;
        run_case("R5 cell", 1'b0, 3'd4, 8'h37, 8'h00, -1, 1'b0);

        // R5: bad last cell
        bad_en = 1'b1; bad_addr = 8'hFF; bad_val = 8'h5A;
        run_case("R5 last cell", 1'b0, 3'd4, 8'hFF, 8'h5A, -1, 1'b0);

        // R7: clean again after failures
        run_case("R7 recover", 1'b1, 3'd0, 8'h00, 8'h00, RUN_CYC, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule